// File: doc/BRIEF.md
# DDR SDRAM Command Monitor with Bank and Timing Tracking

This block watches the command pins of a four-bank double-data-rate SDRAM from the controller side. On every rising clock edge it samples chip select, the three active-low strobes (row, column, write), the clock enable, address bit 10 and the two bank-select bits. It turns that sample into a named command. Alongside the decode it tracks the state of each bank, a global power state, the most recent column burst and a set of cycle counters.

With that state the block judges each command. A command can be wrong for the state it meets, for example a read to a closed bank or a refresh while a row is open. It can also come too soon after an earlier command. Every minimum interval is a parameter counted in clock cycles. When a rule is broken the block raises a one-cycle violation pulse with a code that names the rule. A command that breaks a rule has no effect on the tracked state.

The block is meant for a controller's self-check logic or a verification environment. It has no data path and does not drive the memory.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock enable high and the power state RUN, chip select high decodes to DESEL (0). With chip select low, the (ras_n,cas_n,we_n) patterns decode as: 111 NOP (1), 011 ACT (2), 010 PRE (3), 101 READ (5), 100 WRITE (7), 001 AREF (10), 110 TERM (9), 000 mode-register load. The code appears on cmd_o one cycle after the sampling edge.
- R2: a10 high turns PRE into PREA (4), READ into READA (6) and WRITE into WRITEA (8). PREA closes every open bank. PRE closes only the bank on ba.
- R3: A mode-register load decodes by ba. ba=0 gives MRS_BASE (15), ba=1 gives MRS_EXT (16), and ba=2 or 3 gives MRS_RSVD (17), which is flagged with code 11.
- R4: In RUN with clock enable low, pattern 001 is SREF_ENTER (11) and moves the power state to SELF (2). A NOP or deselect is PDOWN_ENTER (12) and moves it to DOWN (1). Any other command is CKE_BAD (18) with code 12 and leaves the state at RUN. Outside RUN the pins are ignored: clock enable low gives LP_STAY (14) and high gives LP_EXIT (13), which returns the state to RUN (0).
- R5: bank_open_o bit n is set by a legal ACT to bank n. READ or WRITE to a bank that is not open is flagged with code 4. ACT to an open bank is flagged with code 5.
- R6: READ or WRITE fewer than T_RCD cycles after the bank's ACT is flagged with code 6. ACT fewer than T_RP cycles after that bank was precharged is flagged with code 7.
- R7: ACT fewer than T_RRD cycles after the previous ACT is flagged with code 8. A third ACT fewer than T_RC cycles after the ACT two before it is flagged with code 9.
- R8: After READA, or after WRITEA, the bank is locked and no longer shows as open. The lock lasts BURST_LEN/2+T_RP cycles after READA and BURST_LEN/2+T_WR+T_RP cycles after WRITEA. Any command to the bank while it is locked is flagged with code 2. PREA is flagged with code 2 while any bank is locked.
- R9: TERM is legal only while the most recent column command is a READ without auto-precharge issued fewer than BURST_LEN/2 cycles earlier. Otherwise, including after READA or WRITE, it is flagged with code 10.
- R10: AREF, SREF_ENTER, PDOWN_ENTER and every mode-register load are flagged with code 3 unless all four banks are idle.
- R11: Within T_RFC cycles after AREF, any command other than DESEL, NOP, LP_STAY or LP_EXIT is flagged with code 1.
- R12: viol_o is high for exactly the cycle that reports a violating command, with viol_code_o nonzero. When two rules are broken at once, the lower code wins. A violating command changes neither the bank state nor the power state.
- R13: After reset, cmd_o is DESEL, viol_o and viol_code_o are 0, bank_open_o is 0 and pwr_o is RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| a10 | input | 1 | All-bank / auto-precharge qualifier |
| ba | input | 2 | Bank select |
| cmd_o | output | 5 | Decoded command of the previous edge |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 4 | Code of the broken rule, 0 when none |
| bank_open_o | output | 4 | Per-bank row-open flags |
| pwr_o | output | 2 | Power state: 0 RUN, 1 DOWN, 2 SELF |

## Verification
The bench sweeps the gap between each related pair of commands from one cycle to past the limit, so it lands on the exact boundary of every interval. A counter that is off by one shows up as a wrong verdict at that boundary: a legal command flagged, or an early command let through. The auto-precharge lock is swept in the same way, separately for reads and for writes. A design that sized the two locks the same, or that released a lock a cycle late, fails there. Other checks cover cases where a broken design would quietly change state: a violating ACT that still opens its bank, a TERM accepted after a read with auto-precharge, and commands sent while the power state is low that leak into the bank tracker. One check sends a command during the refresh window that breaks two rules at once, to confirm that the lower code is the one reported.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

    typedef enum logic [4:0] {
        CMD_DESEL      = 5'd0,
        CMD_NOP        = 5'd1,
        CMD_ACT        = 5'd2,
        CMD_PRE        = 5'd3,
        CMD_PREA       = 5'd4,
        CMD_READ       = 5'd5,
        CMD_READA      = 5'd6,
        CMD_WRITE      = 5'd7,
        CMD_WRITEA     = 5'd8,
        CMD_TERM       = 5'd9,
        CMD_AREF       = 5'd10,
        CMD_SREF_ENTER = 5'd11,
        CMD_PDN_ENTER  = 5'd12,
        CMD_LP_EXIT    = 5'd13,
        CMD_LP_STAY    = 5'd14,
        CMD_MRS_BASE   = 5'd15,
        CMD_MRS_EXT    = 5'd16,
        CMD_MRS_RSVD   = 5'd17,
        CMD_CKE_BAD    = 5'd18
    } cmd_e;

    typedef enum logic [3:0] {
        VC_NONE     = 4'd0,
        VC_RFC      = 4'd1,
        VC_LOCKED   = 4'd2,
        VC_NOT_IDLE = 4'd3,
        VC_CLOSED   = 4'd4,
        VC_OPEN     = 4'd5,
        VC_RCD      = 4'd6,
        VC_RP       = 4'd7,
        VC_RRD      = 4'd8,
        VC_RC       = 4'd9,
        VC_TERM     = 4'd10,
        VC_MRS      = 4'd11,
        VC_CKE      = 4'd12
    } vcode_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_DOWN = 2'd1,
        PWR_SELF = 2'd2
    } pwr_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_OPEN = 2'd1,
        BK_LOCK = 2'd2
    } bank_e;

    typedef enum logic [1:0] {
        COL_NONE = 2'd0,
        COL_RD   = 2'd1,
        COL_RDA  = 2'd2,
        COL_WR   = 2'd3
    } col_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       a10,
    input  logic [1:0] ba,
    input  pwr_e       pwr,
    output cmd_e       cmd
);

    logic [2:0] strobes;
    assign strobes = {ras_n, cas_n, we_n};

    always_comb begin
        cmd = CMD_NOP;
        if (pwr != PWR_RUN) begin
            // pins other than the clock enable are ignored in low power
            cmd = cke ? CMD_LP_EXIT : CMD_LP_STAY;
        end else if (!cke) begin
            if (!cs_n && strobes == 3'b001) begin
                cmd = CMD_SREF_ENTER;
            end else if (cs_n || strobes == 3'b111) begin
                cmd = CMD_PDN_ENTER;
            end else begin
                cmd = CMD_CKE_BAD;
            end
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case (strobes)
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b010: cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b101: cmd = a10 ? CMD_READA : CMD_READ;
                3'b100: cmd = a10 ? CMD_WRITEA : CMD_WRITE;
                3'b001: cmd = CMD_AREF;
                3'b110: cmd = CMD_TERM;
                3'b000: begin
                    if (ba == 2'd0)      cmd = CMD_MRS_BASE;
                    else if (ba == 2'd1) cmd = CMD_MRS_EXT;
                    else                 cmd = CMD_MRS_RSVD;
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
    import ddr_mon_pkg::*;
#(
    parameter int CW   = 6,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic          pre_i,
    input  logic          lock_i,
    input  logic [CW-1:0] lock_len_i,
    output logic          open_o,
    output logic          idle_o,
    output logic          busy_o,
    output logic          rcd_ok_o,
    output logic          rp_ok_o
);

    localparam logic [CW-1:0] SAT   = '1;
    localparam logic [CW-1:0] K_RCD = CW'(T_RCD);
    localparam logic [CW-1:0] K_RP  = CW'(T_RP);
    localparam logic [CW-1:0] ONE   = CW'(1);

    typedef struct packed {
        bank_e         st;
        logic [CW-1:0] act_age;
        logic [CW-1:0] pre_age;
        logic [CW-1:0] lock;
    } slot_t;

    slot_t s_d, s_q;

    function automatic logic [CW-1:0] age_inc(input logic [CW-1:0] v);
        return (v == SAT) ? v : v + ONE;
    endfunction

    assign open_o   = (s_q.st == BK_OPEN);
    assign busy_o   = (s_q.st == BK_LOCK) && (s_q.lock > ONE);
    assign idle_o   = (s_q.st == BK_IDLE) || ((s_q.st == BK_LOCK) && (s_q.lock <= ONE));
    assign rcd_ok_o = (s_q.act_age >= K_RCD);
    assign rp_ok_o  = (s_q.pre_age >= K_RP);

    always_comb begin
        s_d         = s_q;
        s_d.act_age = age_inc(s_q.act_age);
        s_d.pre_age = age_inc(s_q.pre_age);
        if (s_q.st == BK_LOCK) begin
            if (s_q.lock != '0) s_d.lock = s_q.lock - ONE;
            if (s_q.lock <= ONE) s_d.st = BK_IDLE;
        end
        if (act_i) begin
            s_d.st      = BK_OPEN;
            s_d.act_age = ONE;
        end
        if (pre_i) begin
            s_d.st      = BK_IDLE;
            s_d.pre_age = ONE;
        end
        if (lock_i) begin
            s_d.st      = BK_LOCK;
            s_d.lock    = lock_len_i;
            s_d.pre_age = SAT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= BK_IDLE;
            s_q.act_age <= SAT;
            s_q.pre_age <= SAT;
            s_q.lock    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RC      = 7,
    parameter int T_RFC     = 8,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       a10,
    input  logic [1:0] ba,
    output logic [4:0] cmd_o,
    output logic       viol_o,
    output logic [3:0] viol_code_o,
    output logic [3:0] bank_open_o,
    output logic [1:0] pwr_o
);

    localparam int NBANK   = 4;
    localparam int HALF    = BURST_LEN / 2;
    localparam int RD_LOCK = HALF + T_RP;
    localparam int WR_LOCK = HALF + T_WR + T_RP;
    localparam int SPAN    = T_RC + T_RFC + WR_LOCK + T_RRD + T_RCD + 4;
    localparam int CW      = $clog2(SPAN) + 1;

    localparam logic [CW-1:0] SAT    = '1;
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [CW-1:0] K_RRD  = CW'(T_RRD);
    localparam logic [CW-1:0] K_RC   = CW'(T_RC);
    localparam logic [CW-1:0] K_RFC  = CW'(T_RFC);
    localparam logic [CW-1:0] K_HALF = CW'(HALF);
    localparam logic [CW-1:0] K_RDL  = CW'(RD_LOCK);
    localparam logic [CW-1:0] K_WRL  = CW'(WR_LOCK);

    typedef struct packed {
        cmd_e          cmd;
        logic          viol;
        vcode_e        code;
        pwr_e          pwr;
        logic [CW-1:0] act_age0;
        logic [CW-1:0] act_age1;
        logic [CW-1:0] ref_age;
        col_e          col_kind;
        logic [CW-1:0] col_age;
    } mon_t;

    mon_t m_d, m_q;

    cmd_e              cmd_now;
    logic [NBANK-1:0]  bk_open, bk_idle, bk_busy, bk_rcd_ok, bk_rp_ok;
    logic [NBANK-1:0]  act_v, pre_v, lock_v;
    logic [CW-1:0]     lock_len;

    function automatic logic [CW-1:0] age_inc(input logic [CW-1:0] v);
        return (v == SAT) ? v : v + ONE;
    endfunction

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .a10   (a10),
        .ba    (ba),
        .pwr   (m_q.pwr),
        .cmd   (cmd_now)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ddr_bank_slot #(
            .CW    (CW),
            .T_RCD (T_RCD),
            .T_RP  (T_RP)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_v[b]),
            .pre_i      (pre_v[b]),
            .lock_i     (lock_v[b]),
            .lock_len_i (lock_len),
            .open_o     (bk_open[b]),
            .idle_o     (bk_idle[b]),
            .busy_o     (bk_busy[b]),
            .rcd_ok_o   (bk_rcd_ok[b]),
            .rp_ok_o    (bk_rp_ok[b])
        );
    end

    logic nop_like, all_idle, term_ok, rfc_open;
    vcode_e code;

    assign nop_like = (cmd_now == CMD_DESEL) || (cmd_now == CMD_NOP) ||
                      (cmd_now == CMD_LP_STAY) || (cmd_now == CMD_LP_EXIT);
    assign all_idle = &bk_idle;
    assign term_ok  = (m_q.col_kind == COL_RD) && (m_q.col_age < K_HALF);
    assign rfc_open = (m_q.ref_age < K_RFC);

    // rule checks, lowest code first
    always_comb begin
        code = VC_NONE;
        if (!nop_like && rfc_open) begin
            code = VC_RFC;
        end else begin
            unique case (cmd_now)
                CMD_ACT: begin
                    if (bk_busy[ba])                 code = VC_LOCKED;
                    else if (!bk_idle[ba])           code = VC_OPEN;
                    else if (!bk_rp_ok[ba])          code = VC_RP;
                    else if (m_q.act_age0 < K_RRD)   code = VC_RRD;
                    else if (m_q.act_age1 < K_RC)    code = VC_RC;
                end
                CMD_PRE: begin
                    if (bk_busy[ba]) code = VC_LOCKED;
                end
                CMD_PREA: begin
                    if (|bk_busy) code = VC_LOCKED;
                end
                CMD_READ, CMD_READA, CMD_WRITE, CMD_WRITEA: begin
                    if (bk_busy[ba])         code = VC_LOCKED;
                    else if (!bk_open[ba])   code = VC_CLOSED;
                    else if (!bk_rcd_ok[ba]) code = VC_RCD;
                end
                CMD_TERM: begin
                    if (!term_ok) code = VC_TERM;
                end
                CMD_AREF, CMD_SREF_ENTER, CMD_PDN_ENTER, CMD_MRS_BASE, CMD_MRS_EXT: begin
                    if (!all_idle) code = VC_NOT_IDLE;
                end
                CMD_MRS_RSVD: begin
                    code = all_idle ? VC_MRS : VC_NOT_IDLE;
                end
                CMD_CKE_BAD: code = VC_CKE;
                default: code = VC_NONE;
            endcase
        end
    end

    // state update, applied only for legal commands
    always_comb begin
        m_d          = m_q;
        m_d.cmd      = cmd_now;
        m_d.code     = code;
        m_d.viol     = (code != VC_NONE);
        m_d.act_age0 = age_inc(m_q.act_age0);
        m_d.act_age1 = age_inc(m_q.act_age1);
        m_d.ref_age  = age_inc(m_q.ref_age);
        m_d.col_age  = age_inc(m_q.col_age);
        act_v        = '0;
        pre_v        = '0;
        lock_v       = '0;
        lock_len     = K_RDL;
        if (code == VC_NONE) begin
            unique case (cmd_now)
                CMD_ACT: begin
                    act_v[ba]    = 1'b1;
                    m_d.act_age1 = age_inc(m_q.act_age0);
                    m_d.act_age0 = ONE;
                end
                CMD_PRE:  pre_v[ba] = bk_open[ba];
                CMD_PREA: pre_v     = bk_open;
                CMD_READ: begin
                    m_d.col_kind = COL_RD;
                    m_d.col_age  = ONE;
                end
                CMD_READA: begin
                    m_d.col_kind = COL_RDA;
                    m_d.col_age  = ONE;
                    lock_v[ba]   = 1'b1;
                    lock_len     = K_RDL;
                end
                CMD_WRITE: begin
                    m_d.col_kind = COL_WR;
                    m_d.col_age  = ONE;
                end
                CMD_WRITEA: begin
                    m_d.col_kind = COL_WR;
                    m_d.col_age  = ONE;
                    lock_v[ba]   = 1'b1;
                    lock_len     = K_WRL;
                end
                CMD_TERM:       m_d.col_kind = COL_NONE;
                CMD_AREF:       m_d.ref_age  = ONE;
                CMD_SREF_ENTER: m_d.pwr      = PWR_SELF;
                CMD_PDN_ENTER:  m_d.pwr      = PWR_DOWN;
                CMD_LP_EXIT:    m_d.pwr      = PWR_RUN;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.cmd      <= CMD_DESEL;
            m_q.viol     <= 1'b0;
            m_q.code     <= VC_NONE;
            m_q.pwr      <= PWR_RUN;
            m_q.act_age0 <= SAT;
            m_q.act_age1 <= SAT;
            m_q.ref_age  <= SAT;
            m_q.col_kind <= COL_NONE;
            m_q.col_age  <= SAT;
        end else begin
            m_q <= m_d;
        end
    end

    assign cmd_o       = m_q.cmd;
    assign viol_o      = m_q.viol;
    assign viol_code_o = m_q.code;
    assign bank_open_o = bk_open;
    assign pwr_o       = m_q.pwr;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       cke,
    input logic [1:0] ba,
    input logic [4:0] cmd_o,
    input logic       viol_o,
    input logic [3:0] viol_code_o,
    input logic [3:0] bank_open_o,
    input logic [1:0] pwr_o
);

    assert_code_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o == (viol_code_o != 4'd0 && viol_code_o <= 4'd12));

    assert_viol_keeps_banks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $stable(bank_open_o));

    assert_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 5'd2 && !viol_o) |-> bank_open_o[$past(ba)]);

    assert_refresh_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 5'd10 && !viol_o) |-> (bank_open_o == 4'd0));

    assert_lowpower_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o != 2'd0) |=> ((cmd_o == 5'd13 || cmd_o == 5'd14) && $stable(bank_open_o)));

    assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && $past(cke) && $past(pwr_o) == 2'd0) |-> (cmd_o == 5'd0));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .cke         (cke),
    .ba          (ba),
    .cmd_o       (cmd_o),
    .viol_o      (viol_o),
    .viol_code_o (viol_code_o),
    .bank_open_o (bank_open_o),
    .pwr_o       (pwr_o)
);

// File: tb/ddr_cmd_monitor_test.sv
module ddr_cmd_monitor_test;

    localparam int P_RCD = 3, P_RP = 3, P_RRD = 2, P_RC = 7, P_RFC = 8, P_WR = 2, P_BL = 4;
    localparam int RD_L = P_BL / 2 + P_RP;
    localparam int WR_L = P_BL / 2 + P_WR + P_RP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [4:0] cmd_o;
    logic       viol_o;
    logic [3:0] viol_code_o;
    logic [3:0] bank_open_o;
    logic [1:0] pwr_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ddr_cmd_monitor #(
        .T_RCD(P_RCD), .T_RP(P_RP), .T_RRD(P_RRD), .T_RC(P_RC),
        .T_RFC(P_RFC), .T_WR(P_WR), .BURST_LEN(P_BL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .a10(a10), .ba(ba), .cmd_o(cmd_o),
        .viol_o(viol_o), .viol_code_o(viol_code_o), .bank_open_o(bank_open_o),
        .pwr_o(pwr_o)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic drv(input logic c, r, s, w, k, a, input logic [1:0] b);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = s; we_n = w; cke = k; a10 = a; ba = b;
        @(posedge clk);
        #1;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drv(0, 1, 1, 1, 1, 0, 2'd0);
    endtask
    task automatic act(input logic [1:0] b);            drv(0, 0, 1, 1, 1, 0, b);  endtask
    task automatic pre(input logic [1:0] b, input logic a); drv(0, 0, 1, 0, 1, a, b); endtask
    task automatic rd(input logic [1:0] b, input logic a);  drv(0, 1, 0, 1, 1, a, b); endtask
    task automatic wr(input logic [1:0] b, input logic a);  drv(0, 1, 0, 0, 1, a, b); endtask
    task automatic term();                              drv(0, 1, 1, 0, 1, 0, 2'd0); endtask
    task automatic aref();                              drv(0, 0, 0, 1, 1, 0, 2'd0); endtask
    task automatic mrs(input logic [1:0] b);            drv(0, 0, 0, 0, 1, 0, b);  endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; a10 = 0; ba = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int exp_cmd(input int c, input int pat, input int a);
        if (c != 0) return 0;
        case (pat)
            7: return 1;
            3: return 2;
            2: return (a != 0) ? 4 : 3;
            5: return (a != 0) ? 6 : 5;
            4: return (a != 0) ? 8 : 7;
            1: return 10;
            6: return 9;
            default: return 15;
        endcase
    endfunction

    function automatic int exp_idle_viol(input int cmd);
        if (cmd >= 5 && cmd <= 8) return 4;
        if (cmd == 9) return 10;
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R13 reset state
        chk("R13", "cmd", cmd_o, 0);
        chk("R13", "viol", viol_o, 0);
        chk("R13", "open", bank_open_o, 0);
        chk("R13", "pwr", pwr_o, 0);

        // R1 / R2 exhaustive decode from an all-idle state
        for (int i = 0; i < 32; i++) begin
            int c, pat, a, e;
            c = (i >> 4) & 1; pat = (i >> 1) & 7; a = i & 1;
            do_reset();
            drv(c[0], pat[2], pat[1], pat[0], 1, a[0], 2'd0);
            e = exp_cmd(c, pat, a);
            chk("R1", "decode", cmd_o, e);
            chk("R5", "idle verdict", viol_code_o, exp_idle_viol(e));
            chk("R5", "open after", bank_open_o, (e == 2) ? 1 : 0);
        end

        // R6 tRCD sweep
        for (int d = 1; d <= 5; d++) begin
            do_reset(); act(0); nop(d - 1); rd(0, 0);
            chk("R6", "rcd", viol_code_o, (d < P_RCD) ? 6 : 0);
        end
        // R6 tRP sweep
        for (int d = 1; d <= 5; d++) begin
            do_reset(); act(0); nop(2); pre(0, 0);
            chk("R2", "pre closes", bank_open_o, 0);
            nop(d - 1); act(0);
            chk("R6", "rp", viol_code_o, (d < P_RP) ? 7 : 0);
        end
        // R7 tRRD sweep, R12 violating ACT leaves bank closed
        for (int d = 1; d <= 3; d++) begin
            do_reset(); act(0); nop(d - 1); act(1);
            chk("R7", "rrd", viol_code_o, (d < P_RRD) ? 8 : 0);
            chk("R12", "banks", bank_open_o, (d < P_RRD) ? 1 : 3);
            nop(1);
            chk("R12", "pulse ends", viol_o, 0);
        end
        // R7 two ACTs per tRC
        for (int g = 2; g <= 6; g++) begin
            do_reset(); act(0); nop(1); act(1); nop(g - 1); act(2);
            chk("R7", "rc window", viol_code_o, (2 + g < P_RC) ? 9 : 0);
        end
        // R8 READA lock
        for (int d = 1; d <= RD_L + 1; d++) begin
            do_reset(); act(0); nop(2); rd(0, 1);
            chk("R8", "locked not open", bank_open_o, 0);
            nop(d - 1); act(0);
            chk("R8", "reada lock", viol_code_o, (d < RD_L) ? 2 : 0);
        end
        // R8 WRITEA lock
        for (int d = 1; d <= WR_L + 1; d++) begin
            do_reset(); act(0); nop(2); wr(0, 1); nop(d - 1); act(0);
            chk("R8", "writea lock", viol_code_o, (d < WR_L) ? 2 : 0);
        end
        do_reset(); act(0); nop(2); act(1); nop(2); rd(0, 1); pre(1, 1);
        chk("R8", "prea while locked", viol_code_o, 2);

        // R9 TERM
        for (int d = 1; d <= 3; d++) begin
            do_reset(); act(0); nop(2); rd(0, 0); nop(d - 1); term();
            chk("R9", "term after read", viol_code_o, (d < P_BL / 2) ? 0 : 10);
        end
        do_reset(); act(0); nop(2); rd(0, 1); term();
        chk("R9", "term after reada", viol_code_o, 10);
        do_reset(); act(0); nop(2); wr(0, 0); term();
        chk("R9", "term after write", viol_code_o, 10);

        // R11 refresh window
        for (int d = 1; d <= P_RFC + 1; d++) begin
            do_reset(); aref(); nop(d - 1); act(0);
            chk("R11", "rfc", viol_code_o, (d < P_RFC) ? 1 : 0);
        end
        do_reset(); aref(); rd(0, 0);
        chk("R12", "priority rfc over closed", viol_code_o, 1);

        // R10 all banks idle
        do_reset(); act(1); nop(3); aref();
        chk("R10", "aref open", viol_code_o, 3);
        mrs(0);
        chk("R10", "mrs open", viol_code_o, 3);
        drv(0, 0, 0, 1, 0, 0, 2'd0);
        chk("R10", "sref open cmd", cmd_o, 11);
        chk("R10", "sref open", viol_code_o, 3);
        chk("R12", "pwr unchanged", pwr_o, 0);
        pre(1, 1); drv(0, 1, 1, 1, 0, 0, 2'd0);
        chk("R10", "pdown idle", viol_code_o, 0);

        // R3 mode register select
        for (int b = 0; b < 4; b++) begin
            do_reset(); mrs(b[1:0]);
            chk("R3", "mrs cmd", cmd_o, (b < 2) ? 15 + b : 17);
            chk("R3", "mrs viol", viol_code_o, (b < 2) ? 0 : 11);
        end

        // R4 low power
        do_reset(); drv(0, 1, 1, 1, 0, 0, 2'd0);
        chk("R4", "pdown cmd", cmd_o, 12);
        chk("R4", "pdown state", pwr_o, 1);
        drv(0, 0, 1, 1, 0, 0, 2'd0);
        chk("R4", "stay cmd", cmd_o, 14);
        chk("R4", "stay ignored", bank_open_o, 0);
        chk("R4", "stay viol", viol_o, 0);
        drv(0, 0, 1, 1, 1, 0, 2'd0);
        chk("R4", "exit cmd", cmd_o, 13);
        chk("R4", "exit state", pwr_o, 0);
        chk("R4", "exit ignored", bank_open_o, 0);
        do_reset(); drv(0, 0, 0, 1, 0, 0, 2'd0);
        chk("R4", "sref state", pwr_o, 2);
        drv(1, 1, 1, 1, 1, 0, 2'd0);
        chk("R4", "sref exit", pwr_o, 0);
        do_reset(); drv(0, 0, 1, 1, 0, 0, 2'd0);
        chk("R4", "cke bad cmd", cmd_o, 18);
        chk("R4", "cke bad code", viol_code_o, 12);
        chk("R4", "cke bad pwr", pwr_o, 0);

        // R2 precharge all
        do_reset(); act(0); nop(1); act(3); nop(1);
        chk("R5", "two open", bank_open_o, 9);
        pre(0, 0);
        chk("R2", "single pre", bank_open_o, 8);
        act(0); nop(1); pre(2, 1);
        chk("R2", "prea cmd", cmd_o, 4);
        chk("R2", "prea clears", bank_open_o, 0);
        act(1); act(1);
        chk("R5", "act open bank", viol_code_o, 5);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule